// File: doc/BRIEF.md
# Board Interrupt Level Aggregator

This block collects thirteen level-sensitive interrupt lines from board peripherals and turns them into a single 4-bit interrupt level for a CPU. Each line owns one fixed bit in a 16-bit status vector. That vector follows the input levels directly, with no latching. A firmware-written 16-bit mask selects which of these bits may take part. Among the lines that are both active and enabled, the one with the lowest level number wins. That level number is driven to the CPU bit-inverted, so the value 0 means that no request is pending.

Firmware reaches the block through a 64-byte register window. Every access is 16 bits wide. The window holds:
- a mask register;
- a general-purpose output port that drives board pins;
- a read-only version word;
- a power-off control, which raises a one-cycle shutdown strobe when firmware sets its lowest bit.

The register interface is plain select/write control and has no back-pressure. A write is taken on every clock edge at which it is presented, and read data is valid in the same cycle as the address.

Top module: `irq_level_agg`

## Requirements
- R1: `src_irq[k]` is the request whose level number is k. Its status bit follows the input with no latching: when the line drops, the request disappears from the level output one clock edge later.
- R2: The source at level k maps to one status/mask bit. The bit positions are, for levels 0 to 12 in turn: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. A source takes part only when its mask bit is 1.
- R3: When several sources take part at once, the one with the smallest level number wins, whatever the order of their mask bits.
- R4: `irl_n` carries the winning level XOR 15. When no source takes part, the level is 15 and `irl_n` is 0. Level 0 gives 15.
- R5: `irl_n` is registered. It shows the effect of a change on `src_irq` after the next rising edge. It shows the effect of a mask write after the edge that accepts the write.
- R6: Byte offset 0x00 holds the mask register, which can be read and written. Reads return the last value written.
- R7: Offset 0x36 holds the output port, which can be read and written. Its value drives `port_out` from the edge that accepts the write.
- R8: Offset 0x30 always reads 0. A write there with bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge. A write there with bit 0 clear leaves `shutdown_req` low.
- R9: Offset 0x32 always reads 0x0010. Writes to it change nothing.
- R10: Every other offset, including odd byte addresses, reads 0. Writes to such offsets change neither the mask nor the port.
- R11: After reset the mask and the port are 0, `irl_n` is 0 and `shutdown_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | 13 | Peripheral request levels, indexed by level number |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle as the address |
| irl_n | output | 4 | Inverted winning interrupt level |
| port_out | output | 16 | General output port value |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
Both a change on the request lines and an accepted mask write show on `irl_n` after exactly one rising edge. The bench therefore applies the stimulus at a falling edge and compares at the following falling edge. Read data has no register, so it is compared one time step after the address is driven, within the same cycle. The shutdown strobe is sampled in the cycle after the write edge and again one cycle later, to confirm that it is a single pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_N  = 13;
  localparam int LVL_W  = 4;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 6;

  // Status/mask bit owned by the source at a given level number.
  function automatic int unsigned src_bit(input int unsigned lvl);
    case (lvl)
      0:       return 11;
      1:       return 9;
      2:       return 8;
      3:       return 12;
      4:       return 10;
      5:       return 6;
      6:       return 5;
      7:       return 4;
      8:       return 7;
      9:       return 14;
      10:      return 13;
      11:      return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter int VERSION = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] mask_eff,
  output logic [DW-1:0] port_q,
  output logic          shutdown_req
);
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_PWR  = AW'(48);
  localparam logic [AW-1:0] A_VER  = AW'(50);
  localparam logic [AW-1:0] A_PORT = AW'(54);

  logic [DW-1:0] mask_q;
  logic wr_mask, wr_port, wr_pwr;

  assign wr_mask = bus_sel && bus_wr && (bus_addr == A_MASK);
  assign wr_port = bus_sel && bus_wr && (bus_addr == A_PORT);
  assign wr_pwr  = bus_sel && bus_wr && (bus_addr == A_PWR);

  // Mask as seen this edge: a write takes effect without an extra cycle.
  assign mask_eff = wr_mask ? bus_wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q       <= '0;
      port_q       <= '0;
      shutdown_req <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_port) port_q <= bus_wdata;
      shutdown_req <= wr_pwr && bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_MASK:  bus_rdata = mask_q;
        A_PORT:  bus_rdata = port_q;
        A_VER:   bus_rdata = DW'(VERSION);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio
  import irq_agg_pkg::*;
#(
  parameter int NSRC = SRC_N,
  parameter int LW   = LVL_W,
  parameter int DW   = REG_W
) (
  input  logic [NSRC-1:0] src_irq,
  input  logic [DW-1:0]   mask_eff,
  output logic [LW-1:0]   lvl_n
);
  logic [DW-1:0]   status;
  logic [NSRC-1:0] cand;
  logic [LW-1:0]   lvl;

  always_comb begin
    status = '0;
    for (int k = 0; k < NSRC; k++) status[src_bit(k)] = src_irq[k];
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_cand
    assign cand[g] = status[src_bit(g)] & mask_eff[src_bit(g)];
  end

  // Scan from the top so the smallest enabled level is the last to write.
  always_comb begin
    lvl = '1;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (cand[k]) lvl = LW'(k);
    end
  end

  assign lvl_n = lvl ^ {LW{1'b1}};
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_irq,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [LVL_W-1:0]  irl_n,
  output logic [REG_W-1:0]  port_out,
  output logic              shutdown_req
);
  logic [REG_W-1:0] mask_eff;
  logic [LVL_W-1:0] lvl_n;

  irq_agg_regs #(.DW(REG_W), .AW(ADDR_W), .VERSION(16)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mask_eff(mask_eff), .port_q(port_out), .shutdown_req(shutdown_req)
  );

  irq_agg_prio #(.NSRC(SRC_N), .LW(LVL_W), .DW(REG_W)) u_prio (
    .src_irq(src_irq), .mask_eff(mask_eff), .lvl_n(lvl_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irl_n <= '0;
    else        irl_n <= lvl_n;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] src_irq,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [3:0]  irl_n,
  input logic        shutdown_req
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R4: with no request line high, the output reads idle.
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(src_irq) == 13'd0) |-> irl_n == 4'd0);

  // R3: level 0 enabled through a mask write wins outright.
  assert_top_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(src_irq[0] && bus_sel && bus_wr && bus_addr == 6'h00
                    && bus_wdata[11])) |-> irl_n == 4'hF);

  // R8: the strobe only follows a power-off write with bit 0 set.
  assert_pwr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && shutdown_req) |-> $past(bus_sel && bus_wr && bus_addr == 6'h30
                                      && bus_wdata[0]));

  // R8: the power-off offset reads 0.
  assert_pwr_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 6'h30) |-> bus_rdata == 16'h0000);

  // R9: the version offset reads 0x0010.
  assert_version_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 6'h32) |-> bus_rdata == 16'h0010);

  // R6: a mask write followed at once by a read returns the written value.
  assert_mask_rb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(bus_sel && bus_wr && bus_addr == 6'h00)
     && bus_sel && !bus_wr && bus_addr == 6'h00) |-> bus_rdata == $past(bus_wdata));
endmodule

bind irq_level_agg irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irl_n(irl_n), .shutdown_req(shutdown_req)
);

// File: tb/irq_level_agg_bench.sv
module irq_level_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src_irq = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_n;
  logic [15:0] port_out;
  logic        shutdown_req;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [15:0] m_mask = '0;
  logic [15:0] m_port = '0;

  always #5 clk = ~clk;

  irq_level_agg u_irq_level_agg (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irl_n(irl_n), .port_out(port_out),
    .shutdown_req(shutdown_req)
  );

  function automatic int bit_of(int lvl);
    int tbl[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return tbl[lvl];
  endfunction

  function automatic logic [3:0] exp_irl(logic [12:0] s, logic [15:0] m);
    for (int k = 0; k < 13; k++)
      if (s[k] && m[bit_of(k)]) return 4'(k) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (a == 6'h00) m_mask = d;
    if (a == 6'h36) m_port = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic set_src(logic [12:0] s);
    src_irq = s;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    #1000000;
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 irl", {12'd0, irl_n}, 16'd0);
    check("R11 port", port_out, 16'd0);
    check("R11 shutdown", {15'd0, shutdown_req}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    rd(6'h00, d); check("R11 mask", d, 16'd0);
    // R2: active lines without mask give nothing
    set_src(13'h1FFF); check("R2 masked", {12'd0, irl_n}, 16'd0);
    // R5: mask write shows after its accepting edge
    wr(6'h00, 16'h0001); check("R5 mask write", {12'd0, irl_n}, 16'h4); // level 11
    // R6 readback
    rd(6'h00, d); check("R6 mask rb", d, 16'h0001);
    // R3: out-of-order bits; level 0 (bit 11) beats level 11 (bit 0)
    wr(6'h00, 16'h0801); check("R3 lvl0 wins", {12'd0, irl_n}, 16'hF);
    // R1: drop level 0, level 11 next
    set_src(13'h1FFE); check("R1 drop", {12'd0, irl_n}, 16'h4);
    // R3: level 9 (bit 14) vs level 12 (bit 15) vs level 8 (bit 7)
    wr(6'h00, 16'hC080); check("R3 lvl8", {12'd0, irl_n}, 16'h7);
    set_src(13'h1E00); check("R3 lvl9", {12'd0, irl_n}, 16'h6);
    set_src(13'h1000); check("R4 lvl12", {12'd0, irl_n}, 16'h3);
    set_src(13'h0000); check("R4 idle", {12'd0, irl_n}, 16'h0);
    // R7 port
    wr(6'h36, 16'hA5C3); check("R7 port pins", port_out, 16'hA5C3);
    rd(6'h36, d); check("R7 port rb", d, 16'hA5C3);
    // R8 power-off
    rd(6'h30, d); check("R8 read0", d, 16'h0);
    wr(6'h30, 16'h0001); check("R8 pulse", {15'd0, shutdown_req}, 16'd1);
    @(negedge clk); check("R8 one cycle", {15'd0, shutdown_req}, 16'd0);
    wr(6'h30, 16'hFFFE); check("R8 bit0 clear", {15'd0, shutdown_req}, 16'd0);
    // R9 version
    wr(6'h32, 16'hFFFF);
    rd(6'h32, d); check("R9 version", d, 16'h0010);
    rd(6'h00, d); check("R9 mask intact", d, m_mask);
    // R10 other offsets
    wr(6'h02, 16'h1234); wr(6'h01, 16'h5555); wr(6'h37, 16'h7777);
    rd(6'h02, d); check("R10 read0", d, 16'h0);
    rd(6'h01, d); check("R10 odd read0", d, 16'h0);
    rd(6'h00, d); check("R10 mask kept", d, m_mask);
    check("R10 port kept", port_out, m_port);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 3);
      if (sel == 0) begin
        wr(6'h00, 16'($urandom));
        check("R5 rand mask", {12'd0, irl_n}, {12'd0, exp_irl(src_irq, m_mask)});
      end else begin
        set_src(13'($urandom));
        check("R3 rand", {12'd0, irl_n}, {12'd0, exp_irl(src_irq, m_mask)});
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule